// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Comparator for a Synthesizer Loop

This block sits in the digital part of a frequency-synthesizer loop that runs from a 75 kHz crystal. It divides the crystal clock down to one of six comparison rates and compares that reference against the pulse stream from an external programmable VCO divider. The result drives a three-state charge-pump control: a drive-enable and, when enabled, the level to drive. The pump is driven high when the divided VCO runs ahead, low when it lags, and left floating when the two agree.

A sticky out-of-lock flag watches the pump. It is set when the pump stays enabled for more consecutive crystal cycles than a limit supplied on a port. Software tests it and clears it with a one-cycle strobe. A stop control parks the whole comparison path. Changing the rate code restarts the reference divider, and the pump floats until the first reference edge at the new rate.

All inputs are synchronous to the crystal clock. The divided VCO input is treated as a level whose rising edges are the events.

Top module: `pll_ref_phase_det`

## Requirements
- R1: Rate code `ref_sel` selects the reference period in crystal cycles: 0 gives 75 (1 kHz), 1 gives 25 (3 kHz), 2 gives 15 (5 kHz), 3 gives 12 (6.25 kHz), 4 gives 6 (12.5 kHz) and 5 gives 3 (25 kHz). Codes 6 and 7 give 75. `ref_tick` is a one-cycle pulse once per period.
- R2: While reset is asserted, `pump_oe`, `pump_up`, `unlock_flag` and `ref_tick` are all 0.
- R3: A rising edge of `vco_pulse` while no reference edge is pending makes the pump drive high (`pump_oe`=1, `pump_up`=1) from the next cycle. It stays so until a reference edge arrives.
- R4: A reference edge while no VCO edge is pending makes the pump drive low (`pump_oe`=1, `pump_up`=0) from the cycle after `ref_tick`. It stays so until a VCO edge arrives.
- R5: When the missing edge arrives, the pump floats (`pump_oe`=0) from the next cycle. A VCO edge that coincides with the reference edge leaves the pump floating.
- R6: While `pll_run` is 0, the pump floats from the next cycle and no `ref_tick` occurs. After `pll_run` returns to 1, the first `ref_tick` follows after one full period. Until that tick, VCO edges are ignored.
- R7: When `ref_sel` changes, the pump floats from the next cycle and the divider restarts. The first tick at the new rate comes period+1 cycles after the cycle in which the new code is first presented. VCO edges before that tick are ignored.
- R8: `unlock_flag` is set after `pump_oe` has been 1 for `unlock_limit`+1 consecutive cycles. It then stays set until cleared.
- R9: A one-cycle `unlock_clr` clears `unlock_flag` from the next cycle, unless the set condition of R8 holds in that same cycle, in which case the flag stays set.
- R10: `pump_up` is never 1 while `pump_oe` is 0. The internal up and down requests are never both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock (75 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pll_run | input | 1 | 1 runs the comparator; 0 parks it with the pump floating |
| ref_sel | input | 3 | Reference rate code (see R1) |
| vco_pulse | input | 1 | Output of the external VCO divider; rising edges are events |
| unlock_limit | input | LIM_W | Allowed consecutive pump-active cycles before out-of-lock |
| unlock_clr | input | 1 | One-cycle strobe that clears the out-of-lock flag |
| ref_tick | output | 1 | One-cycle pulse per reference period |
| pump_oe | output | 1 | Charge-pump drive enable; 0 means high impedance |
| pump_up | output | 1 | Driven level when enabled: 1 high, 0 low |
| unlock_flag | output | 1 | Sticky out-of-lock indication |

## Verification
Several properties are checked on every cycle. The up and down requests are never both active. A stop or a code change empties the comparator on the next edge, and the divider restarts from zero. Reference pulses never last two cycles, and the out-of-lock flag is sticky. The bench's scenarios are needed to show the period for every rate code, the restart latency after a code change, the drive direction for leading and lagging VCO edges, and silence when the edges coincide. They also cover the exact cycle in which the flag sets against the programmed limit, and the priority of a set over a coincident clear.

// File: rtl/pll_pd_pkg.sv
package pll_pd_pkg;

  typedef enum logic [2:0] {
    RATE_1K    = 3'd0,
    RATE_3K    = 3'd1,
    RATE_5K    = 3'd2,
    RATE_6K25  = 3'd3,
    RATE_12K5  = 3'd4,
    RATE_25K   = 3'd5
  } rate_code_e;

  localparam int unsigned NUM_CODES = 8;
  localparam int unsigned SLOWEST_HZ = 1000;

  // Comparison rate in Hz for a code; undefined codes fall back to the slowest.
  function automatic int unsigned rate_hz(input logic [2:0] code);
    case (code)
      RATE_3K:   rate_hz = 3000;
      RATE_5K:   rate_hz = 5000;
      RATE_6K25: rate_hz = 6250;
      RATE_12K5: rate_hz = 12500;
      RATE_25K:  rate_hz = 25000;
      default:   rate_hz = SLOWEST_HZ;
    endcase
  endfunction

endpackage

// File: rtl/pd_ref_divider.sv
module pd_ref_divider #(
  parameter int unsigned XTAL_HZ = 75000,
  parameter int unsigned CNT_W   = $clog2(XTAL_HZ / pll_pd_pkg::SLOWEST_HZ)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick,
  output logic       hold
);
  import pll_pd_pkg::*;

  logic [CNT_W-1:0] lim_tab [NUM_CODES];

  // Terminal count per code, derived from the crystal rate.
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_lim
    localparam int unsigned RATIO = XTAL_HZ / rate_hz(3'(i));
    assign lim_tab[i] = CNT_W'(RATIO - 1);
  end

  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             settle_q, settle_d;
  logic             sel_chg, wrap;

  always_comb begin
    sel_chg = (sel != sel_q);
    wrap    = (cnt_q == lim_tab[sel_q]);
    tick_d  = run && !sel_chg && wrap;
    if (!run || sel_chg) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (!run || sel_chg) begin
      settle_d = 1'b1;
    end else if (tick_d) begin
      settle_d = 1'b0;
    end else begin
      settle_d = settle_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      cnt_q    <= '0;
      tick_q   <= 1'b0;
      settle_q <= 1'b1;
    end else begin
      sel_q    <= sel;
      cnt_q    <= cnt_d;
      tick_q   <= tick_d;
      settle_q <= settle_d;
    end
  end

  assign tick = tick_q;
  assign hold = settle_q | sel_chg | ~run;

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_chg && run) |=> (cnt_q == '0 && !tick_q && settle_q));

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  assert_stop_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tick_q && cnt_q == '0));

endmodule

// File: rtl/pd_phase_comp.sv
module pd_phase_comp (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic ref_tick,
  input  logic vco_in,
  output logic up,
  output logic dn
);

  logic vco_q, vco_rise;
  logic up_q, dn_q, up_d, dn_d;
  logic up_n, dn_n;

  always_comb begin
    vco_rise = vco_in & ~vco_q;
    up_n     = up_q | vco_rise;
    dn_n     = dn_q | ref_tick;
    if (hold) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else if (up_n && dn_n) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_n;
      dn_d = dn_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vco_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      vco_q <= vco_in;
      up_q  <= up_d;
      dn_q  <= dn_d;
    end
  end

  assign up = up_q;
  assign dn = dn_q;

  assert_up_dn_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  assert_hold_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !(up_q || dn_q));

endmodule

// File: rtl/pd_lock_monitor.sv
module pd_lock_monitor #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [LIM_W-1:0] limit,
  input  logic             clr,
  output logic             flag
);

  localparam logic [LIM_W-1:0] RUN_MAX = '1;

  logic [LIM_W-1:0] run_q, run_d;
  logic             flag_q, flag_d;
  logic             set_c;

  always_comb begin
    set_c = active && (run_q >= limit);
    if (!active) begin
      run_d = '0;
    end else if (run_q == RUN_MAX) begin
      run_d = run_q;
    end else begin
      run_d = run_q + 1'b1;
    end
    if (set_c) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  assert_flag_needs_activity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(active));

endmodule

// File: rtl/pll_ref_phase_det.sv
module pll_ref_phase_det #(
  parameter int unsigned XTAL_HZ = 75000,
  parameter int unsigned LIM_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_run,
  input  logic [2:0]       ref_sel,
  input  logic             vco_pulse,
  input  logic [LIM_W-1:0] unlock_limit,
  input  logic             unlock_clr,
  output logic             ref_tick,
  output logic             pump_oe,
  output logic             pump_up,
  output logic             unlock_flag
);

  logic rst_meta_n, rst_sync_n;
  logic hold, up, dn;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pd_ref_divider #(.XTAL_HZ(XTAL_HZ)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (pll_run),
    .sel   (ref_sel),
    .tick  (ref_tick),
    .hold  (hold)
  );

  pd_phase_comp u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hold     (hold),
    .ref_tick (ref_tick),
    .vco_in   (vco_pulse),
    .up       (up),
    .dn       (dn)
  );

  assign pump_oe = up | dn;
  assign pump_up = up;

  pd_lock_monitor #(.LIM_W(LIM_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .active (pump_oe),
    .limit  (unlock_limit),
    .clr    (unlock_clr),
    .flag   (unlock_flag)
  );

  assert_clr_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (unlock_clr && !pump_oe) |=> !unlock_flag);

  assert_stop_floats_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pll_run |=> !pump_oe);

endmodule

// File: tb/tb_pll_ref_phase_det.sv
module tb_pll_ref_phase_det;
  localparam int CLK_PERIOD = 10;
  localparam int LIM_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pll_run;
  logic [2:0]       ref_sel;
  logic             vco_pulse;
  logic [LIM_W-1:0] unlock_limit;
  logic             unlock_clr;
  logic             ref_tick, pump_oe, pump_up, unlock_flag;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ref_phase_det #(.XTAL_HZ(75000), .LIM_W(LIM_W)) dut (
    .clk(clk), .rst_n(rst_n), .pll_run(pll_run), .ref_sel(ref_sel),
    .vco_pulse(vco_pulse), .unlock_limit(unlock_limit), .unlock_clr(unlock_clr),
    .ref_tick(ref_tick), .pump_oe(pump_oe), .pump_up(pump_up),
    .unlock_flag(unlock_flag)
  );

  function automatic int exp_ratio(input int code);
    int hz;
    case (code)
      1: hz = 3000;
      2: hz = 5000;
      3: hz = 6250;
      4: hz = 12500;
      5: hz = 25000;
      default: hz = 1000;
    endcase
    return 75000 / hz;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input int code);
    ref_sel = 3'(code);
    pll_run = 1'b0;
    step(2);
    pll_run = 1'b1;
  endtask

  task automatic wait_tick(output int k);
    k = 0;
    do begin
      step(1);
      k++;
    end while (!ref_tick && k < 300);
  endtask

  task automatic pulse_vco;
    vco_pulse = 1'b1;
    step(1);
    vco_pulse = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int k, k2, p;
    bit ok;
    rst_n = 1'b0; pll_run = 1'b1; ref_sel = 3'd0; vco_pulse = 1'b0;
    unlock_limit = 8'd200; unlock_clr = 1'b0;
    step(3);
    chk(!pump_oe && !pump_up && !unlock_flag && !ref_tick, "R2 reset state",
        {pump_oe, pump_up, unlock_flag, ref_tick}, 0);
    rst_n = 1'b1;
    step(4);

    // R1 / R6: every code, first tick after enable and steady period.
    for (int c = 0; c < 8; c++) begin
      restart(c);
      ok = 1'b1;
      k = 0;
      do begin
        step(1);
        k++;
        if (!ref_tick && pump_oe) ok = 1'b0;
      end while (!ref_tick && k < 300);
      chk(k == exp_ratio(c), "R6 first tick after enable", k, exp_ratio(c));
      chk(ok, "R6 pump floats before first tick", ok, 1);
      step(1);
      chk(pump_oe && !pump_up, "R4 ref first drives low", {pump_oe, pump_up}, 2);
      wait_tick(k2);
      chk(k2 + 1 == exp_ratio(c), "R1 reference period", k2 + 1, exp_ratio(c));
    end

    // R5: VCO edges coincident with reference edges keep the pump floating.
    restart(5);
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (pump_oe) ok = 1'b0;
      vco_pulse = ref_tick;
    end
    vco_pulse = 1'b0;
    chk(ok, "R5 coincident edges stay floating", ok, 1);

    // R3 / R4 / R5: direction and cancellation.
    restart(0);
    wait_tick(k);
    step(1);
    chk(pump_oe && !pump_up, "R4 drive low after ref edge", {pump_oe, pump_up}, 2);
    pulse_vco();
    chk(!pump_oe, "R5 vco edge cancels low drive", pump_oe, 0);
    step(3);
    pulse_vco();
    chk(pump_oe && pump_up, "R3 vco first drives high", {pump_oe, pump_up}, 3);
    step(20);
    chk(pump_oe && pump_up, "R3 high drive persists", {pump_oe, pump_up}, 3);
    wait_tick(k);
    step(1);
    chk(!pump_oe && !pump_up, "R5 ref edge cancels high drive", {pump_oe, pump_up}, 0);

    // R6: stop parks the pump and the divider.
    wait_tick(k);
    step(1);
    pll_run = 1'b0;
    step(1);
    chk(!pump_oe, "R6 stop floats pump", pump_oe, 0);
    ok = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (ref_tick || pump_oe) ok = 1'b0;
    end
    chk(ok, "R6 no tick while stopped", ok, 1);
    pll_run = 1'b1;
    step(5);
    pulse_vco();
    step(1);
    chk(!pump_oe, "R6 vco edge ignored before first tick", pump_oe, 0);

    // R7: code change restarts divider.
    restart(0);
    wait_tick(k);
    step(10);
    chk(pump_oe, "R7 pump active before change", pump_oe, 1);
    ref_sel = 3'd2;
    ok = 1'b1;
    k = 0;
    do begin
      step(1);
      k++;
      if (pump_oe) ok = 1'b0;
      if (k == 4) begin
        vco_pulse = 1'b1;
      end else begin
        vco_pulse = 1'b0;
      end
    end while (!ref_tick && k < 300);
    chk(k == exp_ratio(2) + 1, "R7 first tick after change", k, exp_ratio(2) + 1);
    chk(ok, "R7 pump floats during restart", ok, 1);
    step(1);
    chk(pump_oe && !pump_up, "R7 new rate compares", {pump_oe, pump_up}, 2);

    // R8 / R9: out-of-lock flag.
    unlock_limit = 8'd20;
    restart(0);
    unlock_clr = 1'b1;
    step(1);
    unlock_clr = 1'b0;
    wait_tick(k);
    step(1);
    step(9);
    pulse_vco();
    step(2);
    chk(!unlock_flag, "R8 short activity no flag", unlock_flag, 0);
    wait_tick(k);
    step(1);
    chk(pump_oe, "R8 pump active", pump_oe, 1);
    p = 0;
    step(20);
    chk(!unlock_flag, "R8 flag clear at limit", unlock_flag, 0);
    step(1);
    chk(unlock_flag, "R8 flag set past limit", unlock_flag, 1);
    pulse_vco();
    step(5);
    chk(unlock_flag && !pump_oe, "R8 flag sticky", {unlock_flag, pump_oe}, 2);
    unlock_clr = 1'b1;
    step(1);
    unlock_clr = 1'b0;
    chk(!unlock_flag, "R9 clear strobe", unlock_flag, 0);
    wait_tick(k);
    step(30);
    chk(unlock_flag && pump_oe, "R8 flag set again", {unlock_flag, pump_oe}, 3);
    unlock_clr = 1'b1;
    step(1);
    unlock_clr = 1'b0;
    chk(unlock_flag, "R9 set wins over clear", unlock_flag, 1);
    chk(!(pump_up && !pump_oe), "R10 up implies enable", {pump_oe, pump_up}, 3);

    summary();
    $finish;
  end

endmodule